// File: doc/BRIEF.md
# Configurable Serial Audio Output Port

This block turns stereo sample pairs from a receiver core into a three-wire serial stream made of a bit clock, a frame (left/right) clock and a data line. The receiver delivers one frame at a time with a single-cycle `inValid` strobe. Each frame carries a left and a right 24-bit sample, per-channel validity, user and channel-status bits, and a flag that marks the first frame of a 192-frame channel-status block. The port holds the most recent frame and starts sending it at the next left-phase start.

As clock master, the port divides the system (master) clock by four to make the bit clock. Each frame is 64 bit periods long: 32 for the left phase and 32 for the right phase. As slave, it takes the bit clock and frame clock as inputs and samples them with the system clock. In slave mode the bit clock may be asynchronous, may pause, and the two phases may differ in length.

Static configuration inputs select:
- the sample resolution;
- left or right justification;
- a one-bit delay of the first data bit;
- the polarity of each clock;
- a direct sub-frame format that carries the status bits and a block-start marker.

A mute input silences the data line. A sticky flag reports slave-mode sample slips.

Top module: `sao_port`

## Requirements
- R1: In master mode `sclkOut` has a period of 4 `clk` cycles and every frame-clock phase lasts exactly 32 bit periods. The frame clock and the data line change only on the falling edge of the normalised bit clock (`sclkOut` XOR `cfgSclkInv`).
- R2: In left-justified mode the sample MSB is sent at bit 0 of the phase and the bits follow MSB first. A frame written with `inValid` is sent starting at the next left-phase start. Index 0 of every per-channel status pair is the left channel.
- R3: `cfgRes` encodes the resolution: 0 selects 16 bits, 1 selects 20 bits, 2 or 3 selects 24 bits. The sample's top `res` bits are sent. In left-justified mode every later bit of the phase is 0.
- R4: With `cfgDelay` = 1 in left-justified mode, bit 0 of the phase is 0 and the MSB moves to bit 1.
- R5: In right-justified master mode the sample LSB lands on bit 31 of the phase. Every earlier bit equals the sample MSB (sign extension). `cfgDelay` has no effect in this mode.
- R6: With `cfgDirect` = 1 each phase is laid out as follows: bits 0-3 are 0; bits 4-27 carry the 24-bit sample LSB first; bit 28 is V, bit 29 is U, bit 30 is C and bit 31 is Z. Z is 1 in both phases of a frame whose `inBlockStart` was 1, and 0 otherwise.
- R7: `cfgSclkInv` inverts the bit clock, so data then changes on the rising edge of `sclkOut`. `cfgLrInv` inverts the frame clock, so the left phase is `lrclkOut` high.
- R8: In slave mode a phase starts at the first falling edge of the normalised `sclkIn` after the normalised `lrclkIn` changes. Phases of unequal length and a paused bit clock do not disturb the data. Bits past the sample are 0.
- R9: Slave mode together with `cfgRightJust` = 1 is illegal. The port then behaves left-justified and drives `cfgError` high. In every legal configuration `cfgError` is low.
- R10: `slipFlag` becomes set only in slave mode and only after the first frame has been received. It is set by a drop (a second frame arrives before a left-phase start consumes the first) or by a repeat (a left-phase start finds no new frame). It stays set until `slipClear` is pulsed; a simultaneous set wins over the clear.
- R11: With `cfgMute` = 1 the data line is 0 from the next bit onward, while both clocks keep running.
- R12: After reset, `sdata`, `slipFlag` and `sclkOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMaster | input | 1 | 1 = generate clocks, 0 = accept clocks |
| cfgRes | input | 2 | Resolution select (0:16, 1:20, 2/3:24) |
| cfgRightJust | input | 1 | Right-justify data in the phase |
| cfgDelay | input | 1 | One-bit delay of the first data bit |
| cfgSclkInv | input | 1 | Invert bit-clock polarity |
| cfgLrInv | input | 1 | Invert frame-clock polarity |
| cfgDirect | input | 1 | Direct sub-frame format with V/U/C/Z |
| cfgMute | input | 1 | Force data to zero |
| slipClear | input | 1 | Write-one-to-clear pulse for `slipFlag` |
| inValid | input | 1 | New frame strobe |
| inLeft | input | 24 | Left sample |
| inRight | input | 24 | Right sample |
| inValidity | input | 2 | V bits, [0] left, [1] right |
| inUser | input | 2 | U bits, [0] left, [1] right |
| inChStat | input | 2 | C bits, [0] left, [1] right |
| inBlockStart | input | 1 | Frame is first of a channel-status block |
| sclkIn | input | 1 | Slave bit clock |
| lrclkIn | input | 1 | Slave frame clock |
| sclkOut | output | 1 | Master bit clock (0 in slave mode) |
| lrclkOut | output | 1 | Master frame clock (0 in slave mode) |
| sdata | output | 1 | Serial data |
| slipFlag | output | 1 | Sticky slip indication |
| cfgError | output | 1 | Illegal configuration indication |

## Verification
The bench targets the following corner cases:

- **Right-justified padding.** A negative and a positive sample go out right-justified. A design that padded with zeros, or that let the delay shift the word, would show a wrong bit ahead of the MSB.
- **Slave timing.** Slave frames are driven with unequal phase lengths and a mid-phase bit-clock pause. A port that assumed 32-bit phases or counted system-clock cycles would misplace or repeat bits.
- **Direct format.** The test expects Z only in the block-start frame. Swapping V/U/C positions, or leaving Z set in later frames, fails the check.
- **Slips and illegal configurations.** The slip test produces a drop and then a repeat, each followed by a clear. A non-sticky flag, a missed drop or repeat, or a flag raised in master mode shows up. The illegal slave right-justified setting must both raise the error and fall back to left-justified output.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int SAO_POS_W = 8;

  // Per-bit strobes from the clock control to the datapath
  typedef struct packed {
    logic                 bitFall;     // normalised bit clock falls this cycle
    logic                 phaseStart;  // this fall begins a new phase
    logic                 chanRight;   // phase belongs to the right channel
    logic [SAO_POS_W-1:0] bitPos;      // position of the bit about to be driven
  } saoStrobe_t;
endpackage

// File: rtl/sao_ctrl.sv
module sao_ctrl
  import sao_pkg::*;
#(
  parameter int MCLK_DIV    = 4,
  parameter int SLOT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgMaster,
  input  logic       cfgSclkInv,
  input  logic       cfgLrInv,
  input  logic       sclkIn,
  input  logic       lrclkIn,
  output logic       sclkOut,
  output logic       lrclkOut,
  output saoStrobe_t strb
);
  localparam int DIV_W = (MCLK_DIV > 2) ? $clog2(MCLK_DIV) : 1;
  localparam int CNT_W = $clog2(2 * SLOT_W);

  // ---------------- master clock generation ----------------
  logic [DIV_W-1:0] divCnt, divNext;
  logic [CNT_W-1:0] frameCnt, frameNext;
  logic             divWrap;
  logic             sclkInt, lrInt;

  assign divWrap   = (divCnt == DIV_W'(MCLK_DIV - 1));
  assign divNext   = divWrap ? '0 : divCnt + 1'b1;
  assign frameNext = frameCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      frameCnt <= '1;
      sclkInt  <= 1'b0;
      lrInt    <= 1'b1;
    end else if (cfgMaster) begin
      divCnt  <= divNext;
      sclkInt <= (divNext >= DIV_W'(MCLK_DIV / 2));
      if (divWrap) begin
        frameCnt <= frameNext;
        lrInt    <= frameNext[CNT_W-1];
      end
    end
  end

  // ---------------- slave clock tracking ----------------
  logic [SYNC_STAGES-1:0] sclkSync, lrSync;
  logic                   sNorm, lNorm, sPrev, lrLast, fallSlave;
  logic [SAO_POS_W-1:0]   slvPos, slvPosNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      lrSync   <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      lrSync   <= {lrSync[SYNC_STAGES-2:0], lrclkIn};
    end
  end

  assign sNorm     = sclkSync[SYNC_STAGES-1] ^ cfgSclkInv;
  assign lNorm     = lrSync[SYNC_STAGES-1] ^ cfgLrInv;
  assign fallSlave = sPrev & ~sNorm;

  always_comb begin
    if (lNorm != lrLast)     slvPosNext = '0;
    else if (slvPos == '1)   slvPosNext = slvPos;
    else                     slvPosNext = slvPos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sPrev  <= 1'b0;
      lrLast <= 1'b1;
      slvPos <= '0;
    end else begin
      sPrev <= sNorm;
      if (fallSlave && !cfgMaster) begin
        lrLast <= lNorm;
        slvPos <= slvPosNext;
      end
    end
  end

  // ---------------- strobe selection ----------------
  always_comb begin
    if (cfgMaster) begin
      strb.bitFall    = divWrap;
      strb.phaseStart = (frameNext[CNT_W-2:0] == '0);
      strb.chanRight  = frameNext[CNT_W-1];
      strb.bitPos     = SAO_POS_W'(frameNext[CNT_W-2:0]);
    end else begin
      strb.bitFall    = fallSlave;
      strb.phaseStart = (lNorm != lrLast);
      strb.chanRight  = lNorm;
      strb.bitPos     = slvPosNext;
    end
  end

  assign sclkOut  = cfgMaster ? (sclkInt ^ cfgSclkInv) : 1'b0;
  assign lrclkOut = cfgMaster ? (lrInt ^ cfgLrInv) : 1'b0;
endmodule

// File: rtl/sao_dpath.sv
module sao_dpath
  import sao_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int RES_LO   = 16,
  parameter int RES_MID  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  saoStrobe_t          strb,
  input  logic                cfgMaster,
  input  logic [1:0]          cfgRes,
  input  logic                cfgRightJust,
  input  logic                cfgDelay,
  input  logic                cfgDirect,
  input  logic                cfgMute,
  input  logic                slipClear,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic [1:0]          inValidity,
  input  logic [1:0]          inUser,
  input  logic [1:0]          inChStat,
  input  logic                inBlockStart,
  output logic                sdata,
  output logic                slipFlag,
  output logic                cfgError
);
  localparam int IDX_W   = $clog2(SAMPLE_W);
  localparam int HDR_W   = 4;
  localparam int AUD_END = HDR_W + SAMPLE_W;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
    logic [1:0]          v;
    logic [1:0]          u;
    logic [1:0]          c;
    logic                z;
  } frame_t;

  frame_t pending, active, src;
  logic   fresh, primed, frameStart, slipSet, rjEff, bitVal;
  logic [SAMPLE_W-1:0] smp;
  logic [IDX_W-1:0]    bitIdx;
  int                  pos, res, k;

  assign frameStart = strb.bitFall & strb.phaseStart & ~strb.chanRight;
  assign cfgError   = ~cfgMaster & cfgRightJust;
  assign rjEff      = cfgRightJust & cfgMaster;

  always_comb begin
    case (cfgRes)
      2'd0:    res = RES_LO;
      2'd1:    res = RES_MID;
      default: res = SAMPLE_W;
    endcase
  end

  // bit selection for the position about to be driven
  always_comb begin
    src    = frameStart ? pending : active;
    smp    = strb.chanRight ? src.right : src.left;
    pos    = int'(strb.bitPos);
    bitVal = 1'b0;
    bitIdx = '0;
    k      = 0;
    if (cfgDirect) begin
      if (pos >= HDR_W && pos < AUD_END) begin
        bitIdx = IDX_W'(pos - HDR_W);
        bitVal = smp[bitIdx];
      end else if (pos == AUD_END)     bitVal = src.v[strb.chanRight];
      else if (pos == AUD_END + 1)     bitVal = src.u[strb.chanRight];
      else if (pos == AUD_END + 2)     bitVal = src.c[strb.chanRight];
      else if (pos == AUD_END + 3)     bitVal = src.z;
    end else if (rjEff) begin
      k = pos - (SLOT_W - res);
      if (pos >= SLOT_W)  bitVal = 1'b0;
      else if (k < 0)     bitVal = smp[SAMPLE_W-1];
      else begin
        bitIdx = IDX_W'(SAMPLE_W - 1 - k);
        bitVal = smp[bitIdx];
      end
    end else begin
      k = pos - (cfgDelay ? 1 : 0);
      if (k >= 0 && k < res) begin
        bitIdx = IDX_W'(SAMPLE_W - 1 - k);
        bitVal = smp[bitIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             sdata <= 1'b0;
    else if (strb.bitFall) sdata <= cfgMute ? 1'b0 : bitVal;
  end

  // frame buffering and slip detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      active  <= '0;
      fresh   <= 1'b0;
      primed  <= 1'b0;
    end else begin
      if (inValid)
        pending <= '{left: inLeft, right: inRight, v: inValidity,
                     u: inUser, c: inChStat, z: inBlockStart};
      if (frameStart) begin
        active <= pending;
        fresh  <= inValid;
      end else if (inValid) begin
        fresh <= 1'b1;
      end
      primed <= primed | inValid;
    end
  end

  assign slipSet = ~cfgMaster & primed &
                   ((frameStart & ~fresh) | (inValid & fresh & ~frameStart));

  always_ff @(posedge clk) begin
    if (!rstN)          slipFlag <= 1'b0;
    else if (slipSet)   slipFlag <= 1'b1;
    else if (slipClear) slipFlag <= 1'b0;
  end
endmodule

// File: rtl/sao_port.sv
module sao_port
  import sao_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int MCLK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic [1:0]          cfgRes,
  input  logic                cfgRightJust,
  input  logic                cfgDelay,
  input  logic                cfgSclkInv,
  input  logic                cfgLrInv,
  input  logic                cfgDirect,
  input  logic                cfgMute,
  input  logic                slipClear,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic [1:0]          inValidity,
  input  logic [1:0]          inUser,
  input  logic [1:0]          inChStat,
  input  logic                inBlockStart,
  input  logic                sclkIn,
  input  logic                lrclkIn,
  output logic                sclkOut,
  output logic                lrclkOut,
  output logic                sdata,
  output logic                slipFlag,
  output logic                cfgError
);
  saoStrobe_t strb;

  sao_ctrl #(.MCLK_DIV(MCLK_DIV), .SLOT_W(SLOT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgSclkInv(cfgSclkInv),
    .cfgLrInv(cfgLrInv), .sclkIn(sclkIn), .lrclkIn(lrclkIn),
    .sclkOut(sclkOut), .lrclkOut(lrclkOut), .strb(strb)
  );

  sao_dpath #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgMaster(cfgMaster), .cfgRes(cfgRes),
    .cfgRightJust(cfgRightJust), .cfgDelay(cfgDelay), .cfgDirect(cfgDirect),
    .cfgMute(cfgMute), .slipClear(slipClear), .inValid(inValid),
    .inLeft(inLeft), .inRight(inRight), .inValidity(inValidity), .inUser(inUser),
    .inChStat(inChStat), .inBlockStart(inBlockStart),
    .sdata(sdata), .slipFlag(slipFlag), .cfgError(cfgError)
  );
endmodule

// File: rtl/sao_port_chk.sv
module sao_port_chk
  import sao_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgMaster,
  input logic       cfgMute,
  input logic       cfgSclkInv,
  input logic       cfgLrInv,
  input logic       slipClear,
  input logic       sclkOut,
  input logic       lrclkOut,
  input logic       sdata,
  input logic       slipFlag,
  input saoStrobe_t strb
);
  // R1: data holds while the normalised master bit clock stays high
  assert_data_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $past(cfgMaster) && $stable(cfgSclkInv) &&
     (sclkOut ^ cfgSclkInv) && ($past(sclkOut) ^ cfgSclkInv)) |-> $stable(sdata));

  // R1: frame clock moves only together with a falling normalised bit clock
  assert_lr_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $past(cfgMaster) && $stable(cfgSclkInv) && $stable(cfgLrInv) &&
     (lrclkOut != $past(lrclkOut))) |-> (!(sclkOut ^ cfgSclkInv) && ($past(sclkOut) ^ cfgSclkInv)));

  // R11: a bit launched while muted is zero
  assert_mute_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.bitFall) && $past(cfgMute)) |-> !sdata);

  // R10: slip flag is sticky until cleared
  assert_slip_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (slipFlag && !slipClear) |=> slipFlag);

  // R10: master mode never raises a slip
  assert_slip_master_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $past(cfgMaster) && !$past(slipFlag)) |-> !slipFlag);
endmodule

bind sao_port sao_port_chk uChk (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgMute(cfgMute),
  .cfgSclkInv(cfgSclkInv), .cfgLrInv(cfgLrInv), .slipClear(slipClear),
  .sclkOut(sclkOut), .lrclkOut(lrclkOut), .sdata(sdata), .slipFlag(slipFlag),
  .strb(strb)
);

// File: tb/tb_sao_port.sv
`timescale 1ns/1ps
module tb_sao_port;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rstN = 0;
  logic cfgMaster = 1, cfgRightJust = 0, cfgDelay = 0, cfgSclkInv = 0, cfgLrInv = 0;
  logic cfgDirect = 0, cfgMute = 0, slipClear = 0, inValid = 0, inBlockStart = 0;
  logic [1:0] cfgRes = 2'd2, inValidity = 0, inUser = 0, inChStat = 0;
  logic [23:0] inLeft = 0, inRight = 0;
  logic sclkIn = 1, lrclkIn = 1;
  logic sclkOut, lrclkOut, sdata, slipFlag, cfgError;

  int checks = 0, errors = 0;
  bit done = 0;
  localparam int HALF = 8;

  sao_port dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgRes(cfgRes),
    .cfgRightJust(cfgRightJust), .cfgDelay(cfgDelay), .cfgSclkInv(cfgSclkInv),
    .cfgLrInv(cfgLrInv), .cfgDirect(cfgDirect), .cfgMute(cfgMute),
    .slipClear(slipClear), .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .inValidity(inValidity), .inUser(inUser), .inChStat(inChStat),
    .inBlockStart(inBlockStart), .sclkIn(sclkIn), .lrclkIn(lrclkIn),
    .sclkOut(sclkOut), .lrclkOut(lrclkOut), .sdata(sdata), .slipFlag(slipFlag),
    .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected bit at a phase position, built from the requirements
  function automatic logic expBit(int pos, logic [23:0] s, int res, bit rj, bit dly,
                                  bit direct, bit v, bit u, bit c, bit z);
    int k;
    if (direct) begin
      if (pos >= 4 && pos < 28) return s[pos-4];
      if (pos == 28) return v;
      if (pos == 29) return u;
      if (pos == 30) return c;
      if (pos == 31) return z;
      return 1'b0;
    end
    if (rj) begin
      if (pos >= 32) return 1'b0;
      k = pos - (32 - res);
      if (k < 0) return s[23];
      return s[23-k];
    end
    k = pos - (dly ? 1 : 0);
    if (k >= 0 && k < res) return s[23-k];
    return 1'b0;
  endfunction

  function automatic logic [63:0] expWord(int n, logic [23:0] s, int res, bit rj, bit dly,
                                          bit direct, bit v, bit u, bit c, bit z);
    logic [63:0] w = '0;
    for (int p = 0; p < n; p++) w[p] = expBit(p, s, res, rj, dly, direct, v, u, c, z);
    return w;
  endfunction

  task automatic doReset();
    rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [23:0] l, input logic [23:0] r, input logic [1:0] v,
                           input logic [1:0] u, input logic [1:0] c, input logic z);
    @(negedge clk);
    inLeft = l; inRight = r; inValidity = v; inUser = u; inChStat = c; inBlockStart = z;
    inValid = 1;
    @(negedge clk);
    inValid = 0;
    repeat (3) @(negedge clk);
  endtask

  // Capture one full master frame (left then right) at normalised rising edges
  task automatic captureMaster(output logic [63:0] capL, output logic [63:0] capR,
                               output int nl, output int nr, output logic rawLrLeft,
                               output logic rawSclkAtCap);
    logic ps, lastLr, sN, lN;
    bit started, seenRight;
    int pos;
    capL = '0; capR = '0; nl = 0; nr = 0; rawLrLeft = 0; rawSclkAtCap = 0;
    started = 0; seenRight = 0; lastLr = 0; pos = 0;
    ps = sclkOut ^ cfgSclkInv;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      sN = sclkOut ^ cfgSclkInv;
      lN = lrclkOut ^ cfgLrInv;
      if (sN && !ps) begin
        if (!started) begin
          if (lN == 0 && lastLr == 1) begin
            started = 1; pos = 0; rawLrLeft = lrclkOut; rawSclkAtCap = sclkOut;
          end
        end else if (lN != lastLr) begin
          if (lN == 0) break;
          seenRight = 1; pos = 0;
        end
        if (started) begin
          if (lN == 0) begin capL[pos] = sdata; nl++; end
          else begin capR[pos] = sdata; nr++; end
          pos++;
        end
        lastLr = lN;
      end
      ps = sN;
    end
  endtask

  // Drive one slave frame and capture data before each rising edge
  task automatic slaveFrame(input int nl, input int nr, input int pauseAt,
                            output logic [63:0] capL, output logic [63:0] capR);
    capL = '0; capR = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < (ch ? nr : nl); b++) begin
        @(negedge clk);
        sclkIn = 0;
        if (b == 0) lrclkIn = ch[0];
        repeat (HALF) @(negedge clk);
        if (ch == 0) capL[b] = sdata; else capR[b] = sdata;
        sclkIn = 1;
        repeat (HALF) @(negedge clk);
        if (ch == 0 && b == pauseAt) repeat (40) @(negedge clk);
      end
    end
  endtask

  task automatic setCfg(input bit master, input logic [1:0] res, input bit rj, input bit dly,
                        input bit sinv, input bit linv, input bit direct, input bit mute);
    cfgMaster = master; cfgRes = res; cfgRightJust = rj; cfgDelay = dly;
    cfgSclkInv = sinv; cfgLrInv = linv; cfgDirect = direct; cfgMute = mute;
  endtask

  task automatic testReset();
    setCfg(1, 2, 0, 0, 0, 0, 0, 0);
    rstN = 0;
    repeat (3) @(negedge clk);
    check(sdata == 0, "R12", "sdata in reset", 64'(sdata), 0);
    check(slipFlag == 0, "R12", "slipFlag in reset", 64'(slipFlag), 0);
    check(sclkOut == 0, "R12", "sclkOut in reset", 64'(sclkOut), 0);
    check(cfgError == 0, "R9", "cfgError master LJ", 64'(cfgError), 0);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic testMasterLj();
    logic [63:0] l, r; int nl, nr; logic rl, rs; int rises; logic ps;
    setCfg(1, 2, 0, 0, 0, 0, 0, 0);
    doReset();
    rises = 0; ps = sclkOut;
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if (sclkOut && !ps) rises++;
      ps = sclkOut;
    end
    check(rises == 64, "R1", "bit clock rises per 256 clk", 64'(rises), 64);
    sendFrame(24'hA5C3F1, 24'h5A1234, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(nl == 32 && nr == 32, "R1", "bits per phase", 64'({nl[15:0], nr[15:0]}), 64'h00200020);
    check(l == expWord(32, 24'hA5C3F1, 24, 0, 0, 0, 0, 0, 0, 0), "R2", "left 24b LJ", l,
          expWord(32, 24'hA5C3F1, 24, 0, 0, 0, 0, 0, 0, 0));
    check(r == expWord(32, 24'h5A1234, 24, 0, 0, 0, 0, 0, 0, 0), "R2", "right 24b LJ", r,
          expWord(32, 24'h5A1234, 24, 0, 0, 0, 0, 0, 0, 0));
    check(slipFlag == 0, "R10", "no slip in master", 64'(slipFlag), 0);
  endtask

  task automatic testResDelay();
    logic [63:0] l, r; int nl, nr; logic rl, rs;
    setCfg(1, 0, 0, 1, 0, 0, 0, 0);
    doReset();
    sendFrame(24'hFFFFFF, 24'h9ABCDE, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == expWord(32, 24'hFFFFFF, 16, 0, 1, 0, 0, 0, 0, 0), "R3", "16b delayed left", l,
          expWord(32, 24'hFFFFFF, 16, 0, 1, 0, 0, 0, 0, 0));
    check(r[0] == 0 && r[1] == 1, "R4", "delay bit then MSB", 64'(r[1:0]), 64'h2);
    cfgRes = 2'd1; cfgDelay = 0;
    sendFrame(24'hFFFFFF, 24'h123456, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == expWord(32, 24'hFFFFFF, 20, 0, 0, 0, 0, 0, 0, 0), "R3", "20b left", l,
          expWord(32, 24'hFFFFFF, 20, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic testRj();
    logic [63:0] l, r; int nl, nr; logic rl, rs;
    setCfg(1, 0, 1, 1, 0, 0, 0, 0);
    doReset();
    sendFrame(24'h8F3C00, 24'h3C5A00, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == expWord(32, 24'h8F3C00, 16, 1, 0, 0, 0, 0, 0, 0), "R5", "RJ negative sign ext", l,
          expWord(32, 24'h8F3C00, 16, 1, 0, 0, 0, 0, 0, 0));
    check(r == expWord(32, 24'h3C5A00, 16, 1, 0, 0, 0, 0, 0, 0), "R5", "RJ positive", r,
          expWord(32, 24'h3C5A00, 16, 1, 0, 0, 0, 0, 0, 0));
    check(cfgError == 0, "R9", "master RJ legal", 64'(cfgError), 0);
  endtask

  task automatic testDirect();
    logic [63:0] l, r; int nl, nr; logic rl, rs;
    setCfg(1, 0, 0, 1, 0, 0, 1, 0);
    doReset();
    sendFrame(24'h13579B, 24'hECA864, 2'b01, 2'b10, 2'b11, 1);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == expWord(32, 24'h13579B, 24, 0, 0, 1, 1, 0, 1, 1), "R6", "direct left Z=1", l,
          expWord(32, 24'h13579B, 24, 0, 0, 1, 1, 0, 1, 1));
    check(r == expWord(32, 24'hECA864, 24, 0, 0, 1, 0, 1, 1, 1), "R6", "direct right Z=1", r,
          expWord(32, 24'hECA864, 24, 0, 0, 1, 0, 1, 1, 1));
    sendFrame(24'h13579B, 24'hECA864, 2'b01, 2'b10, 2'b11, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l[31] == 0 && r[31] == 0, "R6", "Z cleared next frame", 64'({l[31], r[31]}), 0);
  endtask

  task automatic testPolarity();
    logic [63:0] l, r; int nl, nr; logic rl, rs;
    setCfg(1, 2, 0, 0, 1, 1, 0, 0);
    doReset();
    sendFrame(24'hC0FFEE, 24'h0BADF0, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == expWord(32, 24'hC0FFEE, 24, 0, 0, 0, 0, 0, 0, 0), "R7", "inverted clocks left", l,
          expWord(32, 24'hC0FFEE, 24, 0, 0, 0, 0, 0, 0, 0));
    check(rl == 1, "R7", "left phase lrclk high", 64'(rl), 1);
    check(rs == 0, "R7", "sample edge is sclkOut fall", 64'(rs), 0);
  endtask

  task automatic testMute();
    logic [63:0] l, r; int nl, nr; logic rl, rs;
    setCfg(1, 2, 0, 0, 0, 0, 0, 1);
    doReset();
    sendFrame(24'hFFFFFF, 24'hFFFFFF, 0, 0, 0, 0);
    captureMaster(l, r, nl, nr, rl, rs);
    check(l == 0 && r == 0, "R11", "muted data", l | r, 0);
    check(nl == 32 && nr == 32, "R11", "clocks run while muted", 64'(nl + nr), 64);
  endtask

  task automatic testSlave();
    logic [63:0] l, r;
    setCfg(0, 2, 0, 0, 0, 0, 0, 0);
    sclkIn = 1; lrclkIn = 1;
    doReset();
    repeat (4) @(negedge clk);
    sendFrame(24'hD4E5F6, 24'h2468AC, 0, 0, 0, 0);
    slaveFrame(26, 34, 10, l, r);
    check(l == expWord(26, 24'hD4E5F6, 24, 0, 0, 0, 0, 0, 0, 0), "R8", "slave short left", l,
          expWord(26, 24'hD4E5F6, 24, 0, 0, 0, 0, 0, 0, 0));
    check(r == expWord(34, 24'h2468AC, 24, 0, 0, 0, 0, 0, 0, 0), "R8", "slave long right", r,
          expWord(34, 24'h2468AC, 24, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic testSlaveRj();
    logic [63:0] l, r;
    setCfg(0, 0, 1, 0, 0, 0, 0, 0);
    sclkIn = 1; lrclkIn = 1;
    doReset();
    repeat (4) @(negedge clk);
    check(cfgError == 1, "R9", "slave RJ flagged", 64'(cfgError), 1);
    sendFrame(24'h87654F, 24'h0F0F0F, 0, 0, 0, 0);
    slaveFrame(32, 32, 99, l, r);
    check(l == expWord(32, 24'h87654F, 16, 0, 0, 0, 0, 0, 0, 0), "R9", "slave RJ falls back to LJ", l,
          expWord(32, 24'h87654F, 16, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic testSlip();
    logic [63:0] l, r;
    setCfg(0, 2, 0, 0, 0, 0, 0, 0);
    sclkIn = 1; lrclkIn = 1;
    doReset();
    repeat (4) @(negedge clk);
    sendFrame(24'h111111, 24'h222222, 0, 0, 0, 0);
    slaveFrame(32, 32, 99, l, r);
    check(slipFlag == 0, "R10", "no slip in steady state", 64'(slipFlag), 0);
    sendFrame(24'h333333, 24'h444444, 0, 0, 0, 0);
    sendFrame(24'h555555, 24'h666666, 0, 0, 0, 0);
    check(slipFlag == 1, "R10", "drop sets flag", 64'(slipFlag), 1);
    repeat (20) @(negedge clk);
    check(slipFlag == 1, "R10", "flag sticky", 64'(slipFlag), 1);
    slipClear = 1; @(negedge clk); slipClear = 0; @(negedge clk);
    check(slipFlag == 0, "R10", "W1C clears", 64'(slipFlag), 0);
    slaveFrame(32, 32, 99, l, r);
    check(l == expWord(32, 24'h555555, 24, 0, 0, 0, 0, 0, 0, 0), "R10", "latest frame sent", l,
          expWord(32, 24'h555555, 24, 0, 0, 0, 0, 0, 0, 0));
    check(slipFlag == 0, "R10", "no slip after consume", 64'(slipFlag), 0);
    slaveFrame(32, 32, 99, l, r);
    check(slipFlag == 1, "R10", "repeat sets flag", 64'(slipFlag), 1);
    check(l == expWord(32, 24'h555555, 24, 0, 0, 0, 0, 0, 0, 0), "R10", "repeated sample", l,
          expWord(32, 24'h555555, 24, 0, 0, 0, 0, 0, 0, 0));
    slipClear = 1; @(negedge clk); slipClear = 0; @(negedge clk);
    check(slipFlag == 0, "R10", "second clear", 64'(slipFlag), 0);
  endtask

  initial begin
    testReset();
    testMasterLj();
    testResDelay();
    testRj();
    testDirect();
    testPolarity();
    testMute();
    testSlave();
    testSlaveRj();
    testSlip();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule